// File: doc/BRIEF.md
# Addend-Compensated PTP Time Counter

This block keeps a free-running nanosecond time of day for IEEE 1588 timekeeping. It runs from a reference oscillator that is faster than the nominal tick rate. On every reference clock a 32-bit phase accumulator adds a programmable addend. Each carry out of that accumulator is one nominal tick, and it advances a 64-bit nanosecond counter by a programmable whole-nanosecond period. Software corrects the frequency by nudging the addend. The nominal addend is ceil(2^32 / ratio), where ratio is the oscillator frequency over the tick frequency and must exceed 1.0. For example, 0x999999A4 with a 10 ns period suits an oscillator near 166.67 MHz.

A prescaler counts ticks and emits a one-cycle strobe every N ticks. Downstream periodic pulse generators use this strobe as their clock enable. A synchronous load input sets the time directly. A small register-style port writes the addend, the tick period, the prescaler divisor and a stored 2-bit clock-source code. The clock-source code is not acted upon here.

Top module: `ptp_time_counter`

## Requirements
- R1: On each clock the accumulator becomes (acc + addend) mod 2^32. `tickStrobe` is high for exactly the cycle after each edge at which that addition carried, and low otherwise.
- R2: At the same edge that produces a tick, `timeNs` rises by the tick period, with 64-bit wraparound. Without a tick or a load, `timeNs` holds its value.
- R3: A write to address 0 stores `cfgData[31:0]` as the addend. The new addend is used from the next clock on, and the write clears neither the accumulator nor the time.
- R4: A write to address 1 stores the low TICK_W (8) bits of `cfgData` as the tick period in nanoseconds. Higher data bits are ignored.
- R5: A write to address 2 stores the prescaler divisor N from the low 16 bits, with 0 treated as 1. `prescStrobe` goes high together with `tickStrobe` on every Nth tick since the last strobe, load or reset. If the running count already reaches N, the strobe fires on the next tick.
- R6: A write to address 3 stores the low 2 bits as `clkSelCode`, which is output unchanged. The codes are 0 external precision reference, 1 system clock, 2 alternate clock and 3 RTC input.
- R7: `loadEn` sets `timeNs` to `loadValue` at the next edge and clears the accumulator and the prescaler count. It takes priority over a tick, and no strobe is issued for that edge.
- R8: After reset `timeNs` is 0, both strobes are low and the accumulator is 0. The addend is 0x999999A4, the period 10, the divisor 100 and `clkSelCode` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgAddr | input | 2 | Register select: 0 addend, 1 period, 2 prescaler, 3 clock source |
| cfgData | input | 32 | Write data |
| loadEn | input | 1 | Load time value |
| loadValue | input | 64 | Time value to load |
| timeNs | output | 64 | Nanosecond time of day |
| tickStrobe | output | 1 | One cycle per accumulator carry |
| prescStrobe | output | 1 | One cycle per N ticks |
| clkSelCode | output | 2 | Stored clock-source code |

## Verification
The bench sweeps a set of addends against several tick periods and prescaler divisors. The addends include 0x80000000 (a tick every other cycle), 0xFFFFFFFF (ticks on almost every cycle) and 1 (no tick in the window). The divisors include 0 and 1, where a design without the zero-as-one rule would never strobe or would strobe off-phase. The bench writes the addend in the middle of a run, so a design that reset the accumulator on a write would shift every later tick. It loads a time near 2^64 to show the 64-bit wrap and loads on a carrying edge to show that the load wins. It also writes the period with junk upper bits, which a design that took the wrong bits would turn into a wrong step.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  typedef enum logic [1:0] {
    REG_ADDEND = 2'd0,
    REG_PERIOD = 2'd1,
    REG_PRESC  = 2'd2,
    REG_CLKSEL = 2'd3
  } cfgAddr_e;

  typedef enum logic [1:0] {
    CLK_EXT_REF = 2'd0,
    CLK_SYS     = 2'd1,
    CLK_ALT     = 2'd2,
    CLK_RTC     = 2'd3
  } clkSrc_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic tick;
    logic load;
  } tcStrobes_t;
endpackage

// File: rtl/ptp_tc_cfg.sv
module ptp_tc_cfg #(
  parameter int DATA_W = 32,
  parameter int ACC_W = 32,
  parameter int TICK_W = 8,
  parameter int PRESC_W = 16,
  parameter logic [ACC_W-1:0] ADDEND_RST = 32'h9999_99A4,
  parameter logic [TICK_W-1:0] PERIOD_RST = 8'd10,
  parameter logic [PRESC_W-1:0] PRESC_RST = 16'd100,
  parameter logic [1:0] CLKSEL_RST = 2'd1
) (
  input  logic clk,
  input  logic rst,
  input  logic cfgWrEn,
  input  logic [1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  output logic [ACC_W-1:0] addend,
  output logic [TICK_W-1:0] period,
  output logic [PRESC_W-1:0] presc,
  output logic [1:0] clkSel
);
  import ptp_tc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      addend <= ADDEND_RST;
      period <= PERIOD_RST;
      presc  <= PRESC_RST;
      clkSel <= CLKSEL_RST;
    end else if (cfgWrEn) begin
      case (cfgAddr_e'(cfgAddr))
        REG_ADDEND: addend <= cfgData[ACC_W-1:0];
        REG_PERIOD: period <= cfgData[TICK_W-1:0];
        REG_PRESC:  presc  <= cfgData[PRESC_W-1:0];
        REG_CLKSEL: clkSel <= cfgData[1:0];
        default: ;
      endcase
    end
  end

  // R3: an addend write lands in the register on the next edge
  assert_addend_write_R3: assert property (@(posedge clk) disable iff (rst)
    (cfgWrEn && cfgAddr == 2'd0) |=> addend == $past(cfgData[ACC_W-1:0]));
  // R6: select code only changes through address 3
  assert_clksel_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !(cfgWrEn && cfgAddr == 2'd3) |=> $stable(clkSel));
endmodule

// File: rtl/ptp_tc_ctrl.sv
module ptp_tc_ctrl #(
  parameter int ACC_W = 32,
  parameter int PRESC_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic loadEn,
  input  logic [ACC_W-1:0] addend,
  input  logic [PRESC_W-1:0] presc,
  output ptp_tc_pkg::tcStrobes_t strobes,
  output logic tickStrobe,
  output logic prescStrobe
);
  localparam int CNT_W = PRESC_W + 1;

  logic [ACC_W-1:0] accQ;
  logic [ACC_W:0] accSum;
  logic carry;
  logic [PRESC_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] divLimit;

  assign accSum = {1'b0, accQ} + {1'b0, addend};
  assign carry = accSum[ACC_W];
  assign cntNext = {1'b0, cntQ} + CNT_W'(1);
  assign divLimit = (presc == '0) ? CNT_W'(1) : {1'b0, presc};

  assign strobes.tick = carry & ~loadEn;
  assign strobes.load = loadEn;

  always_ff @(posedge clk) begin
    if (rst || loadEn) begin
      accQ <= '0;
      cntQ <= '0;
      tickStrobe <= 1'b0;
      prescStrobe <= 1'b0;
    end else begin
      accQ <= accSum[ACC_W-1:0];
      tickStrobe <= carry;
      prescStrobe <= 1'b0;
      if (carry) begin
        if (cntNext >= divLimit) begin
          cntQ <= '0;
          prescStrobe <= 1'b1;
        end else begin
          cntQ <= cntNext[PRESC_W-1:0];
        end
      end
    end
  end

  // R5: the prescaled strobe only ever rides on a tick
  assert_presc_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    prescStrobe |-> tickStrobe);
  // R7: load clears the accumulator and suppresses strobes
  assert_load_clears_R7: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (accQ == '0) && !tickStrobe && !prescStrobe);
endmodule

// File: rtl/ptp_tc_datapath.sv
module ptp_tc_datapath #(
  parameter int TIME_W = 64,
  parameter int TICK_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  ptp_tc_pkg::tcStrobes_t strobes,
  input  logic [TICK_W-1:0] period,
  input  logic [TIME_W-1:0] loadValue,
  output logic [TIME_W-1:0] timeNs
);
  localparam int PAD_W = TIME_W - TICK_W;

  always_ff @(posedge clk) begin
    if (rst) timeNs <= '0;
    else if (strobes.load) timeNs <= loadValue;
    else if (strobes.tick) timeNs <= timeNs + {{PAD_W{1'b0}}, period};
  end

  // R2: a tick steps time by the period
  assert_time_step_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.tick |=> timeNs == $past(timeNs) + {{PAD_W{1'b0}}, $past(period)});
  // R2: without tick or load, time holds
  assert_time_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!strobes.tick && !strobes.load) |=> $stable(timeNs));
  // R7: load sets time
  assert_time_load_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> timeNs == $past(loadValue));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int DATA_W = 32,
  parameter int ACC_W = 32,
  parameter int TICK_W = 8,
  parameter int PRESC_W = 16,
  parameter int TIME_W = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic cfgWrEn,
  input  logic [1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic loadEn,
  input  logic [TIME_W-1:0] loadValue,
  output logic [TIME_W-1:0] timeNs,
  output logic tickStrobe,
  output logic prescStrobe,
  output logic [1:0] clkSelCode
);
  import ptp_tc_pkg::*;

  logic [ACC_W-1:0] addend;
  logic [TICK_W-1:0] period;
  logic [PRESC_W-1:0] presc;
  tcStrobes_t strobes;

  ptp_tc_cfg #(.DATA_W(DATA_W), .ACC_W(ACC_W), .TICK_W(TICK_W), .PRESC_W(PRESC_W)) u_cfg (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .addend(addend), .period(period), .presc(presc), .clkSel(clkSelCode)
  );

  ptp_tc_ctrl #(.ACC_W(ACC_W), .PRESC_W(PRESC_W)) u_ctrl (
    .clk(clk), .rst(rst), .loadEn(loadEn), .addend(addend), .presc(presc),
    .strobes(strobes), .tickStrobe(tickStrobe), .prescStrobe(prescStrobe)
  );

  ptp_tc_datapath #(.TIME_W(TIME_W), .TICK_W(TICK_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .period(period),
    .loadValue(loadValue), .timeNs(timeNs)
  );
endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = 2'd0;
  logic [31:0] cfgData = '0;
  logic loadEn = 1'b0;
  logic [63:0] loadValue = '0;
  logic [63:0] timeNs;
  logic tickStrobe, prescStrobe;
  logic [1:0] clkSelCode;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // independent model state
  logic [31:0] mAddend, mAcc;
  logic [7:0] mPeriod;
  logic [15:0] mPresc;
  logic [1:0] mClkSel;
  logic [63:0] mTime;
  int mCnt;
  logic eTick, ePresc;

  ptp_time_counter u_dut (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .loadEn(loadEn), .loadValue(loadValue), .timeNs(timeNs),
    .tickStrobe(tickStrobe), .prescStrobe(prescStrobe), .clkSelCode(clkSelCode)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mAddend = 32'h9999_99A4; mAcc = '0; mPeriod = 8'd10; mPresc = 16'd100;
    mClkSel = 2'd1; mTime = '0; mCnt = 0; eTick = 0; ePresc = 0;
  endtask

  // one clock: update model from the inputs seen at the edge, then compare
  task automatic step();
    logic [32:0] s;
    int lim;
    @(posedge clk);
    s = {1'b0, mAcc} + {1'b0, mAddend};
    if (loadEn) begin
      mTime = loadValue; mAcc = '0; mCnt = 0; eTick = 0; ePresc = 0;
    end else begin
      mAcc = s[31:0]; eTick = s[32]; ePresc = 0;
      if (s[32]) begin
        mTime = mTime + {56'd0, mPeriod};
        lim = (mPresc == 0) ? 1 : int'(mPresc);
        if (mCnt + 1 >= lim) begin mCnt = 0; ePresc = 1; end
        else mCnt++;
      end
    end
    if (cfgWrEn) begin
      case (cfgAddr)
        2'd0: mAddend = cfgData;
        2'd1: mPeriod = cfgData[7:0];
        2'd2: mPresc = cfgData[15:0];
        default: mClkSel = cfgData[1:0];
      endcase
    end
    #1;
    check("R1 tickStrobe", {63'd0, tickStrobe}, {63'd0, eTick});
    check("R2 timeNs", timeNs, mTime);
    check("R5 prescStrobe", {63'd0, prescStrobe}, {63'd0, ePresc});
    check("R6 clkSelCode", {62'd0, clkSelCode}, {62'd0, mClkSel});
  endtask

  task automatic writeCfg(input logic [1:0] a, input logic [31:0] d);
    cfgWrEn = 1; cfgAddr = a; cfgData = d;
    step();
    cfgWrEn = 0; cfgData = '0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] addends[6];
    logic [7:0] periods[3];
    addends = '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0001,
                32'h4000_0000, 32'h9999_99A4, 32'hC000_0001};
    periods = '{8'd1, 8'd10, 8'd255};
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    // R8 reset state
    check("R8 timeNs", timeNs, 64'd0);
    check("R8 tickStrobe", {63'd0, tickStrobe}, 64'd0);
    check("R8 prescStrobe", {63'd0, prescStrobe}, 64'd0);
    check("R8 clkSelCode", {62'd0, clkSelCode}, 64'd1);
    // R8 defaults: 0x999999A4, 10 ns, divide by 100
    run(400);

    // R1 R2 R5 sweep; R3 write while accumulator runs
    for (int a = 0; a < 6; a++)
      for (int p = 0; p < 3; p++)
        for (int n = 0; n < 5; n++) begin
          writeCfg(2'd1, {24'd0, periods[p]});
          writeCfg(2'd2, n);
          writeCfg(2'd0, addends[a]);
          run(37);
        end

    // R4 upper data bits ignored for the period
    writeCfg(2'd1, 32'hFFFF_FF05);
    writeCfg(2'd0, 32'h8000_0000);
    run(12);
    check("R4 period low bits", timeNs - mTime, 64'd0);

    // R6 every code
    for (int c = 0; c < 4; c++) begin
      writeCfg(2'd3, 32'hFFFF_FFFC | c);
      check("R6 code", {62'd0, clkSelCode}, c);
    end

    // R7 load near 64-bit wrap, then R2 wrap
    writeCfg(2'd1, 32'd10);
    writeCfg(2'd2, 32'd3);
    loadEn = 1; loadValue = 64'hFFFF_FFFF_FFFF_FFF0;
    step();
    loadEn = 0;
    check("R7 load time", timeNs, 64'hFFFF_FFFF_FFFF_FFF0);
    run(20);
    // R7 load on a carrying edge: addend all ones carries almost every cycle
    writeCfg(2'd0, 32'hFFFF_FFFF);
    run(3);
    loadEn = 1; loadValue = 64'h1234_5678_9ABC_DEF0;
    step();
    loadEn = 0;
    check("R7 load priority", timeNs, 64'h1234_5678_9ABC_DEF0);
    check("R7 no strobe", {63'd0, tickStrobe}, 64'd0);
    run(30);

    // R3 write does not clear accumulator: half step addend from a mid phase
    writeCfg(2'd0, 32'h6000_0000);
    run(5);
    writeCfg(2'd0, 32'hA000_0000);
    run(20);

    // R8 reset mid-run restores defaults
    rst = 1;
    @(posedge clk); #1;
    rst = 0;
    modelReset();
    check("R8 after reset time", timeNs, 64'd0);
    check("R8 after reset sel", {62'd0, clkSelCode}, 64'd1);
    run(200);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule